// File: doc/BRIEF.md
# Dual Quad-SPI Flash Bus Engine

This engine moves a host byte stream to and from two quad-SPI flash devices. It drives a serial clock, two chip-select lines and two 4-bit data lanes, called lower and upper. The host sets up a transfer with these inputs:

- a direction (write or read),
- an arrangement (parallel or stacked),
- a device select,
- a stripe enable,
- a byte count,
- a clock divisor.

It then pulses `start`. Write bytes are offered on `tx_data`, and each capture is acknowledged with `tx_take`. Read bytes come back on `rx_data`, and each one is marked with `rx_valid`.

In the parallel arrangement, both devices see the same clock and the same chip select. Each device has its own 4-bit lane, so eight data lines are active. With striping on, each unit moves two bytes at once: the even-indexed byte on the lower lane and the odd-indexed byte on the upper lane. With striping off, one byte can be mirrored to both devices, or sent to only one of them. In the stacked arrangement, both devices share the lower lane pins and only one chip select is active. This doubles the flash capacity and gives no gain in speed.

The data lanes are modelled as output, output-enable and input triplets. A deasserted enable stands for high impedance. Flash commands, dummy cycles and register access are left to the host.

Top module: `dqspi_engine`

## Requirements
- R1: After reset, both chip selects are high (inactive), `sclk` is low, both lane enables are low, and `busy`, `done`, `err`, `tx_take` and `rx_valid` are low.
- R2: `sclk` rests low between transfers. While shifting, each half period of `sclk` lasts H system cycles, where H = max(floor(`clk_div`/2), 1). The LSB of `clk_div` is therefore ignored, and the values 0 and 1 behave as 2.
- R3: Each byte leaves a lane as two nibbles, high nibble first. Lane outputs change on falling `sclk` and are valid at rising `sclk`. Inputs are sampled on rising `sclk`.
- R4: In parallel mode (`stacked`=0) with `bus_sel`=2'b11 and `stripe`=0, each byte from `tx_data[7:0]` is driven on both lanes in the same cycles. In parallel mode both chip selects are asserted together, whatever the value of `bus_sel`.
- R5: A striped write (`stripe`=1) moves two bytes per `tx_take`. The even-indexed byte comes from `tx_data[7:0]` and goes to the lower lane. The odd-indexed byte comes from `tx_data[15:8]` and goes to the upper lane.
- R6: A striped read returns each byte pair in one `rx_valid` beat. The even-indexed byte, taken from the lower lane, is on `rx_data[7:0]`. The odd-indexed byte, taken from the upper lane, is on `rx_data[15:8]`.
- R7: An unstriped parallel read returns its byte on `rx_data[7:0]`. The byte comes from the upper lane only when `bus_sel`=2'b10; otherwise it comes from the lower lane, so mirror reads ignore the upper lane.
- R8: In stacked mode, data uses the lower lane pins. `bus_sel`=2'b01 asserts only `cs_lo_n` and `bus_sel`=2'b10 asserts only `cs_hi_n`. `hi_oe` is never raised.
- R9: A `start` is rejected when any of these holds: the byte count is zero; `bus_sel`=2'b00; stacked mode with `bus_sel`=2'b11; striping with an odd count; striping outside parallel mode with `bus_sel`=2'b11. A rejected `start` sets `err`, asserts no chip select and leaves `busy` low. The next accepted `start` clears `err`.
- R10: The chip select falls 3H cycles before the first rising `sclk`: one full period ahead of the first nibble, plus half a period of setup. It rises 2H cycles after the last falling `sclk`.
- R11: `busy` is high from the cycle after an accepted `start` until the chip select is released. `done` is a one-cycle pulse in the first cycle with the chip select released and `busy` low.
- R12: A read raises no lane enable. A write raises enables only on the selected lanes, and only while nibbles are shifting.
- R13: A `start` that arrives while `busy` is high is ignored, and the running transfer completes with its original length.
- R14: `tx_take` pulses for one cycle after each capture of write data. `rx_valid` pulses for one cycle after each completed receive unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| rd_mode | input | 1 | 1 = read, 0 = write |
| stacked | input | 1 | 1 = stacked (shared lane), 0 = parallel |
| bus_sel | input | 2 | 01 lower, 10 upper, 11 both |
| stripe | input | 1 | Split even/odd bytes across lanes |
| xfer_len | input | LEN_W | Transfer length in bytes |
| clk_div | input | DIV_W | System-to-serial clock divisor |
| tx_data | input | 16 | Next write byte, or byte pair when striping |
| tx_take | output | 1 | Write data captured |
| rx_data | output | 16 | Received byte, or byte pair when striping |
| rx_valid | output | 1 | `rx_data` holds a new unit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| err | output | 1 | Last request rejected |
| sclk | output | 1 | Serial clock |
| cs_lo_n | output | 1 | Lower device chip select, active low |
| cs_hi_n | output | 1 | Upper device chip select, active low |
| lo_o | output | 4 | Lower lane data out |
| lo_oe | output | 1 | Lower lane drive enable |
| lo_i | input | 4 | Lower lane data in |
| hi_o | output | 4 | Upper lane data out |
| hi_oe | output | 1 | Upper lane drive enable |
| hi_i | input | 4 | Upper lane data in |

## Verification
The bench first targets lane routing, because most wiring errors stay quiet. It checks stripe order, mirror reads that must ignore the upper lane, the upper-only read source, and a stacked transfer that must stay on the lower pins. A swapped lane or a dropped odd byte shows up as wrong captured nibbles or a wrong `rx_data`. Off-by-one counting in the chip-select lead and trail windows, or in the divisor clamp, shows up as a wrong cycle count between chip-select and clock edges. Rejected requests with odd counts or a stacked request for both devices, and a `start` pulse during a transfer, catch a design that starts anyway, stretches `done` or restarts partway through.

// File: rtl/dqspi_pkg.sv
`timescale 1ns/1ps
package dqspi_pkg;
  localparam int LANES  = 2;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } dq_state_t;

  localparam logic [1:0] SEL_LO   = 2'b01;
  localparam logic [1:0] SEL_HI   = 2'b10;
  localparam logic [1:0] SEL_BOTH = 2'b11;

  typedef struct packed {
    logic       rd;
    logic       stk;
    logic [1:0] sel;
    logic       stripe;
  } dq_cfg_t;
endpackage

// File: rtl/dqspi_clkgen.sv
`timescale 1ns/1ps
module dqspi_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             toggle,
  input  logic [DIV_W-1:0] half,
  output logic             tick,
  output logic             sclk
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;

  assign tick = run && (cnt_q == (half - 1'b1));
  assign sclk = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
      if (tick && toggle) sclk_d = ~sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end
endmodule

// File: rtl/dqspi_lane.sv
`timescale 1ns/1ps
module dqspi_lane
  import dqspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              sample,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic [NIB_W-1:0]  pin_i,
  output logic [NIB_W-1:0]  pin_o,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;

  assign pin_o   = tx_q[BYTE_W-1 -: NIB_W];
  assign rx_byte = rx_q;

  always_comb begin
    tx_d = tx_q;
    if (load)       tx_d = load_byte;
    else if (shift) tx_d = {tx_q[NIB_W-1:0], {NIB_W{1'b0}}};
    rx_d = sample ? {rx_q[NIB_W-1:0], pin_i} : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end
endmodule

// File: rtl/dqspi_ctrl.sv
`timescale 1ns/1ps
module dqspi_ctrl
  import dqspi_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_mode,
  input  logic             stacked,
  input  logic [1:0]       bus_sel,
  input  logic             stripe,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             tick,
  input  logic             sclk,
  output logic             run,
  output logic             toggle,
  output logic [DIV_W-1:0] half,
  output logic             load,
  output logic             shift,
  output logic             sample,
  output dq_cfg_t          cfg,
  output logic             cs_lo_n,
  output logic             cs_hi_n,
  output logic             lo_oe,
  output logic             hi_oe,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             take,
  output logic             rx_valid
);
  dq_state_t        st_q, st_d;
  dq_cfg_t          cfg_q, cfg_d;
  logic [LEN_W-1:0] units_q, units_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic             phase_q, phase_d;
  logic             nib_q, nib_d;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             take_q, rxv_q;
  logic             bad_req;
  logic [DIV_W-1:0] half_req;
  logic             last_unit;

  assign bad_req = (bus_sel == 2'b00) || (xfer_len == '0) ||
                   (stacked && (bus_sel == SEL_BOTH)) ||
                   (stripe && (stacked || (bus_sel != SEL_BOTH) || xfer_len[0]));
  assign half_req  = ((clk_div >> 1) == '0) ? DIV_W'(1) : (clk_div >> 1);
  assign last_unit = (units_q == LEN_W'(1));

  // Strobes for the lanes
  assign load   = ((st_q == ST_LEAD) && tick && phase_q) ||
                  ((st_q == ST_SHIFT) && tick && sclk && nib_q && !last_unit);
  assign shift  = (st_q == ST_SHIFT) && tick && sclk && !nib_q;
  assign sample = (st_q == ST_SHIFT) && tick && !sclk;

  assign run    = (st_q != ST_IDLE);
  assign toggle = (st_q == ST_SHIFT);
  assign half   = half_q;
  assign cfg    = cfg_q;

  assign busy    = run;
  assign cs_lo_n = !(run && (!cfg_q.stk || (cfg_q.sel == SEL_LO)));
  assign cs_hi_n = !(run && (!cfg_q.stk || (cfg_q.sel == SEL_HI)));
  assign lo_oe   = (st_q == ST_SHIFT) && !cfg_q.rd && (cfg_q.stk || cfg_q.sel[0]);
  assign hi_oe   = (st_q == ST_SHIFT) && !cfg_q.rd && !cfg_q.stk && cfg_q.sel[1];
  assign done     = done_q;
  assign err      = err_q;
  assign take     = take_q;
  assign rx_valid = rxv_q;

  always_comb begin
    st_d    = st_q;
    cfg_d   = cfg_q;
    units_d = units_q;
    half_d  = half_q;
    phase_d = phase_q;
    nib_d   = nib_q;
    err_d   = err_q;
    done_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (bad_req) begin
            err_d = 1'b1;
          end else begin
            err_d   = 1'b0;
            st_d    = ST_LEAD;
            phase_d = 1'b0;
            cfg_d   = '{rd: rd_mode, stk: stacked, sel: bus_sel, stripe: stripe};
            units_d = stripe ? (xfer_len >> 1) : xfer_len;
            half_d  = half_req;
          end
        end
      end
      ST_LEAD: begin
        if (tick) begin
          phase_d = !phase_q;
          if (phase_q) begin
            st_d  = ST_SHIFT;
            nib_d = 1'b0;
          end
        end
      end
      ST_SHIFT: begin
        if (tick && sclk) begin
          if (!nib_q) begin
            nib_d = 1'b1;
          end else if (last_unit) begin
            st_d    = ST_TRAIL;
            phase_d = 1'b0;
          end else begin
            units_d = units_q - 1'b1;
            nib_d   = 1'b0;
          end
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          phase_d = !phase_q;
          if (phase_q) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cfg_q   <= '0;
      units_q <= '0;
      half_q  <= DIV_W'(1);
      phase_q <= 1'b0;
      nib_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      take_q  <= 1'b0;
      rxv_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cfg_q   <= cfg_d;
      units_q <= units_d;
      half_q  <= half_d;
      phase_q <= phase_d;
      nib_q   <= nib_d;
      err_q   <= err_d;
      done_q  <= done_d;
      take_q  <= load;
      rxv_q   <= sample && nib_q && cfg_q.rd;
    end
  end
endmodule

// File: rtl/dqspi_engine.sv
`timescale 1ns/1ps
module dqspi_engine
  import dqspi_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                rd_mode,
  input  logic                stacked,
  input  logic [1:0]          bus_sel,
  input  logic                stripe,
  input  logic [LEN_W-1:0]    xfer_len,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic [2*BYTE_W-1:0] tx_data,
  output logic                tx_take,
  output logic [2*BYTE_W-1:0] rx_data,
  output logic                rx_valid,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                sclk,
  output logic                cs_lo_n,
  output logic                cs_hi_n,
  output logic [NIB_W-1:0]    lo_o,
  output logic                lo_oe,
  input  logic [NIB_W-1:0]    lo_i,
  output logic [NIB_W-1:0]    hi_o,
  output logic                hi_oe,
  input  logic [NIB_W-1:0]    hi_i
);
  localparam int PAIR_W = 2 * BYTE_W;

  // Reset: asserted at once, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic             tick, run, toggle, load, shift, sample;
  logic [DIV_W-1:0] half;
  dq_cfg_t          cfg;

  dqspi_ctrl #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .start(start), .rd_mode(rd_mode),
    .stacked(stacked), .bus_sel(bus_sel), .stripe(stripe),
    .xfer_len(xfer_len), .clk_div(clk_div), .tick(tick), .sclk(sclk),
    .run(run), .toggle(toggle), .half(half), .load(load), .shift(shift),
    .sample(sample), .cfg(cfg), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
    .lo_oe(lo_oe), .hi_oe(hi_oe), .busy(busy), .done(done), .err(err),
    .take(tx_take), .rx_valid(rx_valid)
  );

  dqspi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_sync), .run(run), .toggle(toggle),
    .half(half), .tick(tick), .sclk(sclk)
  );

  logic [BYTE_W-1:0] ld_b [LANES];
  logic [BYTE_W-1:0] rx_b [LANES];
  logic [NIB_W-1:0]  p_in [LANES];
  logic [NIB_W-1:0]  p_out[LANES];

  // Lane 0 is lower, lane 1 is upper; the upper lane takes the odd byte when striping
  assign ld_b[0] = tx_data[BYTE_W-1:0];
  assign ld_b[1] = cfg.stripe ? tx_data[PAIR_W-1:BYTE_W] : tx_data[BYTE_W-1:0];
  assign p_in[0] = lo_i;
  assign p_in[1] = hi_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dqspi_lane u_lane (
      .clk(clk), .rst_n(rst_sync), .load(load), .shift(shift),
      .sample(sample), .load_byte(ld_b[g]), .pin_i(p_in[g]),
      .pin_o(p_out[g]), .rx_byte(rx_b[g])
    );
  end

  assign lo_o = p_out[0];
  assign hi_o = p_out[1];

  assign rx_data[BYTE_W-1:0] = (!cfg.stk && !cfg.stripe && (cfg.sel == SEL_HI)) ? rx_b[1] : rx_b[0];
  assign rx_data[PAIR_W-1:BYTE_W] = cfg.stripe ? rx_b[1] : '0;
endmodule

// File: rtl/dqspi_engine_chk.sv
`timescale 1ns/1ps
module dqspi_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic sclk,
  input logic cs_lo_n,
  input logic cs_hi_n,
  input logic lo_oe,
  input logic hi_oe,
  input logic tx_take,
  input logic rx_valid
);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_cs_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_lo_n && cs_hi_n));
  a_r2_sclk_low_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lo_n && cs_hi_n) |-> !sclk);
  a_r12_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_oe || hi_oe) |-> busy);
  a_r9_err_rises_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
  a_r13_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> (busy || done));
  a_r14_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);
  a_r14_rx_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy);
endmodule

bind dqspi_engine dqspi_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .sclk(sclk), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
  .lo_oe(lo_oe), .hi_oe(hi_oe), .tx_take(tx_take), .rx_valid(rx_valid)
);

// File: tb/dqspi_engine_bench.sv
`timescale 1ns/1ps
module dqspi_engine_bench;
  localparam int LEN_W = 16;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, start, rd_mode, stacked, stripe;
  logic [1:0]       bus_sel;
  logic [LEN_W-1:0] xfer_len;
  logic [DIV_W-1:0] clk_div;
  logic [15:0]      tx_data, rx_data;
  logic             tx_take, rx_valid, busy, done, err, sclk, cs_lo_n, cs_hi_n;
  logic [3:0]       lo_o, hi_o, lo_i, hi_i;
  logic             lo_oe, hi_oe;

  dqspi_engine #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_dqspi_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .stacked(stacked), .bus_sel(bus_sel), .stripe(stripe),
    .xfer_len(xfer_len), .clk_div(clk_div), .tx_data(tx_data),
    .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .done(done), .err(err), .sclk(sclk), .cs_lo_n(cs_lo_n),
    .cs_hi_n(cs_hi_n), .lo_o(lo_o), .lo_oe(lo_oe), .lo_i(lo_i),
    .hi_o(hi_o), .hi_oe(hi_oe), .hi_i(hi_i)
  );

  int n_checks = 0, n_fail = 0;

  // Monitor state
  int cyc = 0, n_lo, n_hi, rises, first_rise, last_rise, last_fall;
  int cs_fall_c, cs_rise_c, per_min, per_max, done_cnt, takes, n_rx, fl_idx, tx_idx;
  bit cs_lo_seen, cs_hi_seen, lo_oe_seen, hi_oe_seen, busy_seen, done_wide, done_bad;
  bit cs_prev = 0, sclk_prev = 0, done_prev = 0, b_stripe = 0;
  logic [3:0]  cap_lo [0:63];
  logic [3:0]  cap_hi [0:63];
  logic [15:0] rx_cap [0:31];
  logic [7:0]  txm    [0:31];

  function automatic logic [7:0] src_lo(input int k);
    return 8'h5A + 8'(k * 37);
  endfunction
  function automatic logic [7:0] src_hi(input int k);
    return 8'hC3 ^ 8'(k * 29);
  endfunction

  task automatic chk_eq(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  task automatic drive_pins();
    logic [7:0] bl, bh;
    bl = src_lo(fl_idx / 2);
    bh = src_hi(fl_idx / 2);
    lo_i = (fl_idx % 2 == 1) ? bl[3:0] : bl[7:4];
    hi_i = (fl_idx % 2 == 1) ? bh[3:0] : bh[7:4];
    if (b_stripe)
      tx_data = (2 * tx_idx + 1 < 32) ? {txm[2*tx_idx+1], txm[2*tx_idx]} : 16'h0;
    else
      tx_data = (tx_idx < 32) ? {8'h00, txm[tx_idx]} : 16'h0;
  endtask

  task automatic mon_clear();
    n_lo = 0; n_hi = 0; rises = 0; first_rise = 0; last_rise = 0; last_fall = 0;
    cs_fall_c = 0; cs_rise_c = 0; per_min = 1000; per_max = 0; done_cnt = 0;
    takes = 0; n_rx = 0; fl_idx = 0; tx_idx = 0;
    cs_lo_seen = 0; cs_hi_seen = 0; lo_oe_seen = 0; hi_oe_seen = 0;
    busy_seen = 0; done_wide = 0; done_bad = 0;
  endtask

  // Sampling away from the active edge; also plays the two flash devices
  always @(negedge clk) begin
    bit cs_any;
    cyc = cyc + 1;
    cs_any = !cs_lo_n || !cs_hi_n;
    if (!cs_lo_n) cs_lo_seen = 1;
    if (!cs_hi_n) cs_hi_seen = 1;
    if (lo_oe) lo_oe_seen = 1;
    if (hi_oe) hi_oe_seen = 1;
    if (busy) busy_seen = 1;
    if (cs_any && !cs_prev) begin cs_fall_c = cyc; fl_idx = 0; end
    if (!cs_any && cs_prev) cs_rise_c = cyc;
    if (sclk && !sclk_prev) begin
      if (rises == 0) first_rise = cyc;
      else begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      rises++;
      if (lo_oe && n_lo < 64) begin cap_lo[n_lo] = lo_o; n_lo++; end
      if (hi_oe && n_hi < 64) begin cap_hi[n_hi] = hi_o; n_hi++; end
    end
    if (!sclk && sclk_prev) begin last_fall = cyc; fl_idx++; end
    if (done) begin
      done_cnt++;
      if (done_prev) done_wide = 1;
      if (busy || cs_any) done_bad = 1;
    end
    if (rx_valid && n_rx < 32) begin rx_cap[n_rx] = rx_data; n_rx++; end
    if (tx_take) begin takes++; tx_idx++; end
    drive_pins();
    cs_prev = cs_any; sclk_prev = sclk; done_prev = done;
  end

  bit busy_after_start;

  task automatic do_xfer(input bit rd, input bit stk, input logic [1:0] sel, input bit str,
                         input int len, input logic [7:0] div, input int poke);
    @(negedge clk);
    mon_clear();
    b_stripe = str;
    for (int i = 0; i < 32; i++) txm[i] = 8'h11 * 8'(i) ^ 8'h96;
    rd_mode = rd; stacked = stk; bus_sel = sel; stripe = str;
    xfer_len = LEN_W'(len); clk_div = div; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_after_start = busy;
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      xfer_len = LEN_W'(len + 4); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 4000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1 cs_lo_n", cs_lo_n, 1);
    chk_eq("R1 cs_hi_n", cs_hi_n, 1);
    chk_eq("R1 sclk", sclk, 0);
    chk_eq("R1 oe", {lo_oe, hi_oe}, 0);
    chk_eq("R1 busy/done/err/take/rxv", {busy, done, err, tx_take, rx_valid}, 0);
  endtask

  task automatic t_mirror_write();
    do_xfer(0, 0, 2'b11, 0, 3, 8'd0, 0);
    chk_eq("R4 lo nibbles", n_lo, 6);
    chk_eq("R4 hi nibbles", n_hi, 6);
    for (int k = 0; k < 3; k++) begin
      chk_eq("R3 R4 lo byte", {cap_lo[2*k], cap_lo[2*k+1]}, txm[k]);
      chk_eq("R4 hi byte", {cap_hi[2*k], cap_hi[2*k+1]}, txm[k]);
    end
    chk_eq("R4 both cs", {cs_lo_seen, cs_hi_seen}, 2'b11);
    chk_eq("R2 period div0", per_max, 2);
    chk_eq("R14 takes", takes, 3);
  endtask

  task automatic t_stripe_write();
    do_xfer(0, 0, 2'b11, 1, 4, 8'd4, 0);
    chk_eq("R5 takes", takes, 2);
    for (int k = 0; k < 2; k++) begin
      chk_eq("R5 even byte lower", {cap_lo[2*k], cap_lo[2*k+1]}, txm[2*k]);
      chk_eq("R5 odd byte upper", {cap_hi[2*k], cap_hi[2*k+1]}, txm[2*k+1]);
    end
  endtask

  task automatic t_stripe_read();
    do_xfer(1, 0, 2'b11, 1, 4, 8'd4, 0);
    chk_eq("R14 rx beats", n_rx, 2);
    for (int j = 0; j < 2; j++)
      chk_eq("R6 pair", rx_cap[j], {src_hi(j), src_lo(j)});
    chk_eq("R12 read no oe", {lo_oe_seen, hi_oe_seen}, 0);
  endtask

  task automatic t_mirror_read();
    do_xfer(1, 0, 2'b11, 0, 3, 8'd4, 0);
    chk_eq("R7 rx beats", n_rx, 3);
    for (int j = 0; j < 3; j++)
      chk_eq("R7 mirror read lower", rx_cap[j], {8'h00, src_lo(j)});
  endtask

  task automatic t_upper_read();
    do_xfer(1, 0, 2'b10, 0, 2, 8'd4, 0);
    for (int j = 0; j < 2; j++)
      chk_eq("R7 upper-only read", rx_cap[j], {8'h00, src_hi(j)});
    chk_eq("R12 read no oe upper", {lo_oe_seen, hi_oe_seen}, 0);
  endtask

  task automatic t_stacked_upper();
    do_xfer(0, 1, 2'b10, 0, 2, 8'd4, 0);
    chk_eq("R8 only upper cs", {cs_lo_seen, cs_hi_seen}, 2'b01);
    chk_eq("R8 upper pins idle", hi_oe_seen, 0);
    for (int k = 0; k < 2; k++)
      chk_eq("R8 shared lower pins", {cap_lo[2*k], cap_lo[2*k+1]}, txm[k]);
  endtask

  task automatic t_timing();
    do_xfer(0, 0, 2'b01, 0, 2, 8'd7, 0);
    chk_eq("R10 lead cycles", first_rise - cs_fall_c, 9);
    chk_eq("R10 trail cycles", cs_rise_c - last_fall, 6);
    chk_eq("R2 period min", per_min, 6);
    chk_eq("R2 period max", per_max, 6);
    chk_eq("R12 lower only oe", {lo_oe_seen, hi_oe_seen}, 2'b10);
    chk_eq("R11 busy after start", busy_after_start, 1);
    chk_eq("R11 done count", done_cnt, 1);
    chk_eq("R11 done width", done_wide, 0);
    chk_eq("R11 done with release", done_bad, 0);
  endtask

  task automatic t_reject();
    @(negedge clk);
    mon_clear();
    rd_mode = 0; stacked = 0; bus_sel = 2'b11; stripe = 1; xfer_len = 5; clk_div = 4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk_eq("R9 odd stripe err", err, 1);
    chk_eq("R9 no cs", {cs_lo_seen, cs_hi_seen}, 0);
    chk_eq("R9 no busy", busy_seen, 0);
    stacked = 1; stripe = 0; xfer_len = 2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk_eq("R9 stacked both err", err, 1);
    chk_eq("R9 stacked both no cs", {cs_lo_seen, cs_hi_seen, busy_seen}, 0);
    do_xfer(0, 0, 2'b01, 0, 1, 8'd2, 0);
    chk_eq("R9 err cleared", err, 0);
  endtask

  task automatic t_restart();
    do_xfer(0, 0, 2'b11, 0, 2, 8'd4, 5);
    repeat (40) @(negedge clk);
    chk_eq("R13 rises", rises, 4);
    chk_eq("R13 single done", done_cnt, 1);
    chk_eq("R13 idle", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; rd_mode = 0; stacked = 0; bus_sel = 2'b11;
    stripe = 0; xfer_len = '0; clk_div = 8'd4;
    lo_i = 4'h0; hi_i = 4'h0; tx_data = 16'h0;
    mon_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mirror_write();
    t_stripe_write();
    t_stripe_read();
    t_mirror_read();
    t_upper_read();
    t_stacked_upper();
    t_timing();
    t_reject();
    t_restart();
    summary();
    $finish;
  end
endmodule